// File: doc/BRIEF.md
# Peak Current Mode PWM Modulator

This block drives one power switch of a switching converter. An internal period counter starts every switching period and turns the gate on. Within that period, the gate is turned off on the clock after the sensed current, with an offset added, reaches the commanded peak. The command is first limited to a programmable ceiling, so the peak switch current is bounded no matter what the outer loop asks for.

A blanking window at the start of each period ignores current samples there, so turn-on ringing cannot end the pulse early. Minimum and maximum on-time limits bound the pulse from both sides. Once the pulse has ended, the gate stays low until the next period starts. A one-clock status strobe tells which cause ended the pulse: a current trip or the on-time ceiling.

The outer voltage compensator drives the command input. The current sample arrives as an unsigned digital word, either from an ADC or from a comparator output scaled to full range.

Top module: `peak_cm_pwm`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it is released, `gate`, `trip_pulse` and `maxd_pulse` are 0.
- R2: The first rising clock edge that samples `enable` high starts a period, and `gate` goes high on that edge. A new period then starts every `period` clocks (counter positions 0 to `period`-1, with `period` >= 2). Each period start drives `gate` high again, unless `max_on` is 0.
- R3: The threshold is the smaller of `command` and `cmd_limit`, so a command above the limit behaves exactly like the limit.
- R4: The compared level is `sense` + `offset`, unsigned, saturating at 2^DATA_W-1 instead of wrapping. The current has been reached when level >= threshold.
- R5: The current has been reached at counter position c while `gate` is high. If c >= `blank_len` and c+1 >= `min_on`, `gate` is low from the next clock on, which gives an on-time of c+1 clocks.
- R6: A reached current at a position below `blank_len` does not end the pulse.
- R7: A current trip never ends the pulse before `gate` has been high for `min_on` clocks.
- R8: `gate` is high for at most `max_on` clocks per period, even if no trip occurs. This limit also applies when `blank_len` is longer than `max_on`. `max_on` = 0 keeps `gate` low. If `max_on` >= `period` and no trip occurs, `gate` stays high for the whole period.
- R9: After the pulse has ended, `gate` stays low for the rest of the period, even if the sensed current falls back below the threshold.
- R10: On every clock edge that samples `enable` low, `gate` goes low and the period counter is restarted.
- R11: On the first clock of a pulse end, exactly one status output is high for one clock. `trip_pulse` marks a current trip. `maxd_pulse` marks the on-time ceiling, which wins if both causes occur at the same position. A pulse cut by the next period start gives no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Synchronous run enable, active high |
| sense | input | DATA_W | Sensed current sample, unsigned |
| command | input | DATA_W | Peak current command from the outer loop |
| cmd_limit | input | DATA_W | Ceiling applied to the command |
| offset | input | DATA_W | Added to the sensed sample before comparison |
| period | input | CNT_W | Switching period in clocks |
| min_on | input | CNT_W | Minimum on-time in clocks |
| max_on | input | CNT_W | Maximum on-time in clocks |
| blank_len | input | CNT_W | Blanking window length in clocks |
| gate | output | 1 | Switch drive |
| trip_pulse | output | 1 | One-clock strobe: pulse ended on current |
| maxd_pulse | output | 1 | One-clock strobe: pulse ended on the on-time ceiling |

## Verification
A sweep runs over two periods and over grids of minimum on-time, blanking length and maximum on-time. Each point is tried once with a current that never reaches the threshold and once with a current that is always above it. The measured on-time then shows which limit ended the pulse: blanking, minimum, ceiling or a full period. Directed cases set command against limit, and sense against offset near the top of the range. These separate clamping from no clamping and saturation from wrap-around. Two further cases check the status strobes when the sensed current drops after a trip, and check the restart when enable is dropped in the middle of a pulse.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  typedef enum logic [1:0] {
    END_NONE = 2'd0,
    END_TRIP = 2'd1,
    END_MAXD = 2'd2
  } end_cause_e;

  // Position test on counter-width values widened by one bit.
  function automatic logic at_least(input int unsigned a, input int unsigned b);
    return a >= b;
  endfunction
endpackage

// File: rtl/pcm_timer.sv
module pcm_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] pos,
  output logic             running,
  output logic             wrap
);
  logic [CNT_W:0] next_pos;

  assign next_pos = {1'b0, pos} + 1'b1;
  // A period begins on the next edge when idle or at the last position.
  assign wrap = enable && (!running || pcm_pkg::at_least(int'(next_pos), int'(period)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos     <= '0;
      running <= 1'b0;
    end else if (!enable) begin
      pos     <= '0;
      running <= 1'b0;
    end else begin
      running <= 1'b1;
      pos     <= wrap ? '0 : next_pos[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/pcm_compare.sv
module pcm_compare #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] sense,
  input  logic [DATA_W-1:0] offset,
  input  logic [DATA_W-1:0] command,
  input  logic [DATA_W-1:0] cmd_limit,
  output logic              hit
);
  function automatic logic [DATA_W-1:0] sat_add(input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b);
    logic [DATA_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[DATA_W] ? {DATA_W{1'b1}} : s[DATA_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] clamp(input logic [DATA_W-1:0] c,
                                              input logic [DATA_W-1:0] lim);
    return (c > lim) ? lim : c;
  endfunction

  logic [DATA_W-1:0] level;
  logic [DATA_W-1:0] thresh;

  assign level  = sat_add(sense, offset);
  assign thresh = clamp(command, cmd_limit);
  assign hit    = level >= thresh;
endmodule

// File: rtl/pcm_gate_ctl.sv
module pcm_gate_ctl #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             wrap,
  input  logic [CNT_W-1:0] pos,
  input  logic             hit,
  input  logic [CNT_W-1:0] blank_len,
  input  logic [CNT_W-1:0] min_on,
  input  logic [CNT_W-1:0] max_on,
  output logic             gate,
  output logic             trip_flag,
  output logic             maxd_flag
);
  import pcm_pkg::*;

  logic [CNT_W:0] elapsed;
  logic           past_blank;
  logic           min_met;
  logic           at_max;
  logic           trip_ok;
  end_cause_e     cause;

  assign elapsed    = {1'b0, pos} + 1'b1;
  assign past_blank = at_least(int'(pos), int'(blank_len));
  assign min_met    = at_least(int'(elapsed), int'(min_on));
  assign at_max     = at_least(int'(elapsed), int'(max_on));
  assign trip_ok    = hit && past_blank && min_met;

  always_comb begin
    cause = END_NONE;
    if (gate && !wrap) begin
      if (at_max)       cause = END_MAXD;
      else if (trip_ok) cause = END_TRIP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate      <= 1'b0;
      trip_flag <= 1'b0;
      maxd_flag <= 1'b0;
    end else if (!enable) begin
      gate      <= 1'b0;
      trip_flag <= 1'b0;
      maxd_flag <= 1'b0;
    end else if (wrap) begin
      gate      <= (max_on != '0);
      trip_flag <= 1'b0;
      maxd_flag <= 1'b0;
    end else begin
      gate      <= gate && (cause == END_NONE);
      trip_flag <= (cause == END_TRIP);
      maxd_flag <= (cause == END_MAXD);
    end
  end
endmodule

// File: rtl/peak_cm_pwm.sv
module peak_cm_pwm #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [DATA_W-1:0] sense,
  input  logic [DATA_W-1:0] command,
  input  logic [DATA_W-1:0] cmd_limit,
  input  logic [DATA_W-1:0] offset,
  input  logic [CNT_W-1:0]  period,
  input  logic [CNT_W-1:0]  min_on,
  input  logic [CNT_W-1:0]  max_on,
  input  logic [CNT_W-1:0]  blank_len,
  output logic              gate,
  output logic              trip_pulse,
  output logic              maxd_pulse
);
  logic [CNT_W-1:0] pos_w;
  logic             run_w;
  logic             wrap_w;
  logic             hit_w;
  logic             at_start_w;

  pcm_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .period  (period),
    .pos     (pos_w),
    .running (run_w),
    .wrap    (wrap_w)
  );

  pcm_compare #(.DATA_W(DATA_W)) u_cmp (
    .sense     (sense),
    .offset    (offset),
    .command   (command),
    .cmd_limit (cmd_limit),
    .hit       (hit_w)
  );

  pcm_gate_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .wrap      (wrap_w),
    .pos       (pos_w),
    .hit       (hit_w),
    .blank_len (blank_len),
    .min_on    (min_on),
    .max_on    (max_on),
    .gate      (gate),
    .trip_flag (trip_pulse),
    .maxd_flag (maxd_pulse)
  );

  // Named event for the checker: the counter sits at the first position of a period.
  assign at_start_w = run_w && (pos_w == '0);
endmodule

// File: rtl/pcm_checker.sv
module pcm_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             gate,
  input logic             trip_pulse,
  input logic             maxd_pulse,
  input logic [CNT_W-1:0] pos,
  input logic             at_start,
  input logic [CNT_W-1:0] blank_len,
  input logic [CNT_W-1:0] min_on,
  input logic [CNT_W-1:0] max_on
);
  AST_ENABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !gate); // R10
  AST_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> at_start); // R2
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(trip_pulse && maxd_pulse)); // R11
  AST_FLAG_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_pulse || maxd_pulse) |-> (!gate && $past(gate))); // R11
  AST_BLANKING: assert property (@(posedge clk) disable iff (!rst_n)
    trip_pulse |-> ($past(pos) >= $past(blank_len))); // R6
  AST_MIN_ON: assert property (@(posedge clk) disable iff (!rst_n)
    trip_pulse |-> (({1'b0, $past(pos)} + 1'b1) >= {1'b0, $past(min_on)})); // R7
  AST_MAX_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> (pos < max_on)); // R8
endmodule

bind peak_cm_pwm pcm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .gate       (gate),
  .trip_pulse (trip_pulse),
  .maxd_pulse (maxd_pulse),
  .pos        (pos_w),
  .at_start   (at_start_w),
  .blank_len  (blank_len),
  .min_on     (min_on),
  .max_on     (max_on)
);

// File: tb/test_peak_cm_pwm.sv
`timescale 1ns/1ps
module test_peak_cm_pwm;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [7:0] sense = '0, command = '0, cmd_limit = '0, offset = '0;
  logic [7:0] period = 8'd8, min_on = '0, max_on = '0, blank_len = '0;
  logic gate, trip_pulse, maxd_pulse;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  peak_cm_pwm i_peak_cm_pwm (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sense(sense), .command(command),
    .cmd_limit(cmd_limit), .offset(offset), .period(period), .min_on(min_on),
    .max_on(max_on), .blank_len(blank_len), .gate(gate), .trip_pulse(trip_pulse),
    .maxd_pulse(maxd_pulse)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit reached(input int s, input int o, input int c, input int l);
    int lvl, thr;
    lvl = (s + o > 255) ? 255 : s + o;
    thr = (c < l) ? c : l;
    return lvl >= thr;
  endfunction

  task automatic configure(input int p, input int mn, input int bl, input int mx,
                           input int s, input int o, input int c, input int l);
    @(negedge clk) enable = 1'b0;
    repeat (2) @(negedge clk);
    period = 8'(p); min_on = 8'(mn); blank_len = 8'(bl); max_on = 8'(mx);
    sense = 8'(s); offset = 8'(o); command = 8'(c); cmd_limit = 8'(l);
  endtask

  // Three periods with constant inputs; expected on-time from the requirements.
  task automatic run_cfg(input int p, input int mn, input int bl, input int mx,
                         input int s, input int o, input int c, input int l,
                         input string force_tag);
    int ct, cm, stop, len, tf, mf, hi, tr, md;
    string tag;
    bit first;
    configure(p, mn, bl, mx, s, o, c, l);
    ct = reached(s, o, c, l) ? ((mn - 1 > bl) ? mn - 1 : bl) : 1 << 30;
    cm = mx - 1;
    tf = 0; mf = 0;
    if (mx == 0) begin
      len = 0; tag = "R8";
    end else begin
      stop = (ct < cm) ? ct : cm;
      if (stop <= p - 2) begin
        len = stop + 1;
        if (cm <= ct) begin mf = 1; tag = "R8"; end
        else begin
          tf = 1;
          if (ct == bl && bl > mn - 1) tag = "R6";
          else if (mn - 1 > bl) tag = "R7";
          else tag = "R5";
        end
      end else begin
        len = p; tag = "R2";
      end
    end
    if (force_tag != "") tag = force_tag;
    @(negedge clk) enable = 1'b1;
    hi = 0; tr = 0; md = 0; first = 0;
    for (int k = 0; k < 3 * p; k++) begin
      @(negedge clk);
      if (k == 0) first = gate;
      hi += int'(gate); tr += int'(trip_pulse); md += int'(maxd_pulse);
    end
    chk(first == (len > 0), {tag, " start"}, int'(first), int'(len > 0));
    chk(hi == 3 * len, {tag, " on-time"}, hi, 3 * len);
    chk(tr == 3 * tf, "R11 trip strobes", tr, 3 * tf);
    chk(md == 3 * mf, "R11 max strobes", md, 3 * mf);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(gate == 0 && trip_pulse == 0 && maxd_pulse == 0, "R1 in reset",
        int'({gate, trip_pulse, maxd_pulse}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(gate == 0 && trip_pulse == 0 && maxd_pulse == 0, "R1 after release",
        int'({gate, trip_pulse, maxd_pulse}), 0);

    // Sweep: on-time limited by blanking, minimum, ceiling or period.
    foreach (period[i]) begin end
    for (int pi = 0; pi < 2; pi++)
      for (int mi = 0; mi < 3; mi++)
        for (int bi = 0; bi < 4; bi++)
          for (int xi = 0; xi < 4; xi++)
            for (int hcase = 0; hcase < 2; hcase++) begin
              int p, bl;
              p  = (pi == 0) ? 5 : 8;
              bl = (bi == 3) ? 6 : bi;
              run_cfg(p, 2 * mi, bl, 3 * xi, hcase ? 120 : 10, 0, 100, 255, "");
            end

    // R3 clamp of the command
    run_cfg(8, 0, 0, 8, 60, 0, 200, 50, "R3");
    run_cfg(8, 0, 0, 8, 40, 0, 200, 50, "R3");
    run_cfg(8, 0, 0, 8, 40, 0, 30, 50, "R3");
    // R4 offset with saturation
    run_cfg(8, 0, 0, 8, 100, 200, 255, 255, "R4");
    run_cfg(8, 0, 0, 8, 100, 100, 255, 255, "R4");
    run_cfg(8, 0, 1, 8, 0, 0, 0, 0, "R4");

    // R9: the latch holds after the current drops back
    configure(8, 0, 2, 8, 120, 0, 100, 255);
    @(negedge clk) enable = 1'b1;
    begin
      int hi;
      hi = 0;
      for (int k = 0; k < 3; k++) begin @(negedge clk); hi += int'(gate); end
      chk(hi == 3, "R5 on-time before trip", hi, 3);
      @(negedge clk);
      chk(gate == 0, "R9 low after trip", int'(gate), 0);
      chk(trip_pulse == 1, "R11 trip strobe", int'(trip_pulse), 1);
      sense = 8'd10;
      hi = 0;
      for (int k = 0; k < 4; k++) begin @(negedge clk); hi += int'(gate); end
      chk(hi == 0, "R9 stays low with current below threshold", hi, 0);
      @(negedge clk);
      chk(gate == 1, "R2 next period start", int'(gate), 1);
    end

    // R10: enable dropped in mid-pulse, counter restarts
    configure(8, 0, 0, 4, 10, 0, 100, 255);
    @(negedge clk) enable = 1'b1;
    @(negedge clk);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(gate == 0, "R10 gate low after disable", int'(gate), 0);
    sense = 8'd120;
    begin
      int hi;
      hi = 0;
      for (int k = 0; k < 3; k++) begin @(negedge clk); hi += int'(gate); end
      chk(hi == 0, "R10 held low while disabled", hi, 0);
      sense = 8'd10;
      enable = 1'b1;
      hi = 0;
      for (int k = 0; k < 8; k++) begin @(negedge clk); hi += int'(gate); end
      chk(hi == 4, "R10 restart gives full period", hi, 4);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule